// File: doc/BRIEF.md
# Greedy-Then-Youngest Warp Issue Scheduler

This block chooses, each clock, at most one warp of a sub-core whose oldest buffered instruction goes to issue. For every warp the surrounding pipeline presents the state of that instruction: whether one is buffered, whether the warp's fixed-latency stall counter has run down to zero, the zero flags of the warp's dependence counters with the mask of counters the instruction waits on, the execution unit it targets, its yield bit and whether its constant operand (if any) hits in the constant cache.

The scheduler is greedy: the warp that issued last keeps issuing for as long as it stays eligible. When it drops out, the youngest eligible warp (highest launch index) takes over. A yield bit on the issued instruction keeps that warp out of the next cycle. The block tracks execution-unit input latches itself: a half-width unit keeps its latch for two cycles, a full-width unit for one. A constant-cache miss on the chosen warp holds issue for a bounded number of cycles before the scheduler moves on to another ready warp.

Top module: `warp_issue_sched`

## Requirements
- R1: At most one warp is issued per clock; `issue_warp_oh` has at most one bit set.
- R2: A warp is issued only if it has a buffered instruction, its stall-zero flag is set, and every dependence counter selected by its wait mask (bit `w*NUM_DEPCTR+k`) reports zero.
- R3: If the warp issued most recently is still eligible and its constant operand hits, it is issued again, even when a younger warp is eligible.
- R4: When the most recent warp is not eligible, or after reset when there is none, the eligible warp with the highest index is chosen.
- R5: A warp whose issued instruction carried the yield bit is not issued in the following cycle; if no other warp is eligible that cycle issues nothing.
- R6: Each warp names its target unit in field `warp_unit[w*UNIT_W +: UNIT_W]`. A unit with its bit set in `HALF_MASK` (default units 1 and 3) cannot accept an instruction in the cycle right after accepting one; any other unit can accept every cycle.
- R7: If the chosen warp has `warp_cc_hit` low, nothing issues for `MISS_WAIT` (default 4) consecutive cycles; on the next cycle the youngest other eligible warp with a hit is issued, if there is one.
- R8: Outputs are registered: the decision made from the inputs at one rising edge appears after that edge; during and right after reset all outputs are zero.
- R9: `issue_warp_id` is the binary index of the issued warp and `issue_warp_oh` has only that bit set; both are zero when `issue_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_inst_valid | input | NUM_WARPS | Warp has a buffered oldest instruction |
| warp_stall_zero | input | NUM_WARPS | Warp's stall counter is zero |
| warp_dep_zero | input | NUM_WARPS*NUM_DEPCTR | Zero flags of each warp's dependence counters |
| warp_dep_mask | input | NUM_WARPS*NUM_DEPCTR | Counters the oldest instruction waits on |
| warp_unit | input | NUM_WARPS*UNIT_W | Target execution unit of the oldest instruction |
| warp_yield | input | NUM_WARPS | Yield bit of the oldest instruction |
| warp_cc_hit | input | NUM_WARPS | Constant operand present in cache (or not needed) |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp_oh | output | NUM_WARPS | One-hot issued warp |
| issue_warp_id | output | WID_W | Encoded issued warp |

## Verification
The hardest situation to reach is the constant-cache miss timeout, since it needs the warp the scheduler is focused on to stay eligible with a miss for the full wait window while another warp is ready to take over, and random inputs rarely hold a miss on the focused warp that long. Directed sequences first pin the focus on a known warp through greedy issue, then drop only that warp's hit flag with all other warps ready, and later repeat it with no alternative so the hold continues past the window. Random phases then mix yields, half-width targets and brief misses against a cycle-accurate reference model in the bench.

// File: rtl/wis_pkg.sv
package wis_pkg;

   typedef enum logic {
      LATCH_FULL = 1'b0,
      LATCH_HALF = 1'b1
   } latch_kind_e;

   function automatic latch_kind_e latch_kind(input logic half_bit);
      return half_bit ? LATCH_HALF : LATCH_FULL;
   endfunction

endpackage

// File: rtl/wis_pick.sv
module wis_pick #(
   parameter int N     = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/wis_elig.sv
module wis_elig #(
   parameter int NUM_WARPS  = 8,
   parameter int NUM_DEPCTR = 6,
   parameter int NUM_UNITS  = 4,
   localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic [NUM_WARPS-1:0]            inst_valid,
   input  logic [NUM_WARPS-1:0]            stall_zero,
   input  logic [NUM_WARPS*NUM_DEPCTR-1:0] dep_zero,
   input  logic [NUM_WARPS*NUM_DEPCTR-1:0] dep_mask,
   input  logic [NUM_WARPS*UNIT_W-1:0]     unit_sel,
   input  logic [NUM_UNITS-1:0]            unit_free,
   input  logic [NUM_WARPS-1:0]            blocked,
   output logic [NUM_WARPS-1:0]            elig
);

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic              deps_clear;
      logic [UNIT_W-1:0] tgt;
      assign deps_clear = &(dep_zero[w*NUM_DEPCTR +: NUM_DEPCTR]
                            | ~dep_mask[w*NUM_DEPCTR +: NUM_DEPCTR]);
      assign tgt        = unit_sel[w*UNIT_W +: UNIT_W];
      assign elig[w]    = inst_valid[w] & stall_zero[w] & deps_clear
                          & unit_free[tgt] & ~blocked[w];
   end

endmodule

// File: rtl/wis_latch.sv
module wis_latch
   import wis_pkg::*;
#(
   parameter int                 NUM_UNITS = 4,
   parameter logic [NUM_UNITS-1:0] HALF_MASK = 4'b1010,
   localparam int                UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic [UNIT_W-1:0]    take_unit,
   output logic [NUM_UNITS-1:0] unit_free
);

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      if (latch_kind(HALF_MASK[u]) == LATCH_HALF) begin : g_half
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= take && (take_unit == UNIT_W'(u));
         end
         assign unit_free[u] = ~busy_q;
      end else begin : g_full
         assign unit_free[u] = 1'b1;
      end
   end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
   parameter int                   NUM_WARPS  = 8,
   parameter int                   NUM_DEPCTR = 6,
   parameter int                   NUM_UNITS  = 4,
   parameter logic [NUM_UNITS-1:0] HALF_MASK  = 4'b1010,
   parameter int                   MISS_WAIT  = 4,
   localparam int                  UNIT_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
   localparam int                  WID_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int                  MCNT_W     = $clog2(MISS_WAIT + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_WARPS-1:0]            warp_inst_valid,
   input  logic [NUM_WARPS-1:0]            warp_stall_zero,
   input  logic [NUM_WARPS*NUM_DEPCTR-1:0] warp_dep_zero,
   input  logic [NUM_WARPS*NUM_DEPCTR-1:0] warp_dep_mask,
   input  logic [NUM_WARPS*UNIT_W-1:0]     warp_unit,
   input  logic [NUM_WARPS-1:0]            warp_yield,
   input  logic [NUM_WARPS-1:0]            warp_cc_hit,
   output logic                            issue_valid,
   output logic [NUM_WARPS-1:0]            issue_warp_oh,
   output logic [WID_W-1:0]                issue_warp_id
);

   if (NUM_WARPS < 2) begin : g_bad_warps
      $error("warp_issue_sched: NUM_WARPS must be at least 2");
   end
   if (NUM_DEPCTR < 1) begin : g_bad_dep
      $error("warp_issue_sched: NUM_DEPCTR must be at least 1");
   end
   if ((1 << UNIT_W) != NUM_UNITS) begin : g_bad_units
      $error("warp_issue_sched: NUM_UNITS must be a power of two");
   end
   if (MISS_WAIT < 1) begin : g_bad_wait
      $error("warp_issue_sched: MISS_WAIT must be at least 1");
   end

   // scheduler state
   logic              focus_v;
   logic [WID_W-1:0]  focus_id;
   logic              yield_hold;
   logic [MCNT_W-1:0] miss_cnt;

   logic [NUM_WARPS-1:0] blocked;
   logic [NUM_WARPS-1:0] elig_vec;
   logic [NUM_UNITS-1:0] unit_free;

   assign blocked = yield_hold ? (NUM_WARPS'(1) << focus_id) : '0;

   wis_elig #(
      .NUM_WARPS (NUM_WARPS),
      .NUM_DEPCTR(NUM_DEPCTR),
      .NUM_UNITS (NUM_UNITS)
   ) u_elig (
      .inst_valid(warp_inst_valid),
      .stall_zero(warp_stall_zero),
      .dep_zero  (warp_dep_zero),
      .dep_mask  (warp_dep_mask),
      .unit_sel  (warp_unit),
      .unit_free (unit_free),
      .blocked   (blocked),
      .elig      (elig_vec)
   );

   // youngest eligible warp
   logic             yng_found;
   logic [WID_W-1:0] yng_id;

   wis_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pick_yng (
      .req  (elig_vec),
      .found(yng_found),
      .idx  (yng_id)
   );

   // greedy choice
   logic             keep_focus;
   logic             pick_v;
   logic [WID_W-1:0] pick_id;

   assign keep_focus = focus_v & elig_vec[focus_id];
   assign pick_v     = keep_focus | yng_found;
   assign pick_id    = keep_focus ? focus_id : yng_id;

   // alternate warp after a constant-cache timeout
   logic [NUM_WARPS-1:0] alt_req;
   logic                 alt_found;
   logic [WID_W-1:0]     alt_id;

   assign alt_req = elig_vec & warp_cc_hit & ~(NUM_WARPS'(1) << pick_id);

   wis_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pick_alt (
      .req  (alt_req),
      .found(alt_found),
      .idx  (alt_id)
   );

   // issue decision
   logic              fire;
   logic [WID_W-1:0]  fire_id;
   logic              miss_wait;
   logic [MCNT_W-1:0] miss_nxt;

   always_comb begin
      fire      = 1'b0;
      fire_id   = pick_id;
      miss_wait = 1'b0;
      miss_nxt  = '0;
      if (pick_v) begin
         if (warp_cc_hit[pick_id]) begin
            fire = 1'b1;
         end else if (miss_cnt < MCNT_W'(MISS_WAIT)) begin
            miss_wait = 1'b1;
            miss_nxt  = miss_cnt + MCNT_W'(1);
         end else if (alt_found) begin
            fire    = 1'b1;
            fire_id = alt_id;
         end else begin
            miss_nxt = miss_cnt;
         end
      end
   end

   logic [UNIT_W-1:0] fire_unit;
   assign fire_unit = warp_unit[fire_id*UNIT_W +: UNIT_W];

   wis_latch #(
      .NUM_UNITS(NUM_UNITS),
      .HALF_MASK(HALF_MASK)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (fire),
      .take_unit(fire_unit),
      .unit_free(unit_free)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         focus_v       <= 1'b0;
         focus_id      <= '0;
         yield_hold    <= 1'b0;
         miss_cnt      <= '0;
         issue_valid   <= 1'b0;
         issue_warp_oh <= '0;
         issue_warp_id <= '0;
      end else begin
         miss_cnt      <= miss_nxt;
         yield_hold    <= fire & warp_yield[fire_id];
         issue_valid   <= fire;
         issue_warp_oh <= fire ? (NUM_WARPS'(1) << fire_id) : '0;
         issue_warp_id <= fire ? fire_id : '0;
         if (fire) begin
            focus_v  <= 1'b1;
            focus_id <= fire_id;
         end else if (miss_wait) begin
            focus_v  <= 1'b1;
            focus_id <= pick_id;
         end
      end
   end

endmodule

// File: rtl/wis_chk.sv
module wis_chk #(
   parameter int                   NUM_WARPS = 8,
   parameter int                   NUM_UNITS = 4,
   parameter logic [NUM_UNITS-1:0] HALF_MASK = 4'b1010,
   localparam int                  UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
   localparam int                  WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_WARPS-1:0]        warp_yield,
   input logic [NUM_WARPS-1:0]        warp_cc_hit,
   input logic [NUM_WARPS*UNIT_W-1:0] warp_unit,
   input logic [NUM_WARPS-1:0]        elig_vec,
   input logic                        issue_valid,
   input logic [NUM_WARPS-1:0]        issue_warp_oh,
   input logic [WID_W-1:0]            issue_warp_id
);

   logic [NUM_WARPS-1:0]        yield_d, hit_d, elig_d;
   logic [NUM_WARPS*UNIT_W-1:0] unit_d;
   logic [UNIT_W-1:0]           iss_unit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         yield_d <= '0;
         hit_d   <= '0;
         elig_d  <= '0;
         unit_d  <= '0;
      end else begin
         yield_d <= warp_yield;
         hit_d   <= warp_cc_hit;
         elig_d  <= elig_vec;
         unit_d  <= warp_unit;
      end
   end

   assign iss_unit = unit_d[issue_warp_id*UNIT_W +: UNIT_W];

   // R1
   single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(issue_warp_oh));

   // R9
   encode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> issue_warp_oh[issue_warp_id]);

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> (issue_warp_oh == '0 && issue_warp_id == '0));

   // R2
   issued_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> elig_d[issue_warp_id]);

   // R7
   issued_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> hit_d[issue_warp_id]);

   // R5
   yield_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && yield_d[issue_warp_id])
      |=> !(issue_valid && issue_warp_id == $past(issue_warp_id)));

   // R6
   half_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && HALF_MASK[iss_unit])
      |=> !(issue_valid && iss_unit == $past(iss_unit)));

endmodule

bind warp_issue_sched wis_chk #(
   .NUM_WARPS(NUM_WARPS),
   .NUM_UNITS(NUM_UNITS),
   .HALF_MASK(HALF_MASK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .warp_yield   (warp_yield),
   .warp_cc_hit  (warp_cc_hit),
   .warp_unit    (warp_unit),
   .elig_vec     (elig_vec),
   .issue_valid  (issue_valid),
   .issue_warp_oh(issue_warp_oh),
   .issue_warp_id(issue_warp_id)
);

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;

   localparam int             NW   = 8;
   localparam int             ND   = 6;
   localparam int             NU   = 4;
   localparam int             UW   = 2;
   localparam int             IW   = 3;
   localparam logic [NU-1:0]  HALF = 4'b1010;
   localparam int             MW   = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NW-1:0]  v, sz, yl, hit;
   logic [NW*ND-1:0] dz, dm;
   logic [NW*UW-1:0] un;
   logic           issue_valid;
   logic [NW-1:0]  issue_warp_oh;
   logic [IW-1:0]  issue_warp_id;

   always #10 clk = ~clk;

   warp_issue_sched #(
      .NUM_WARPS(NW), .NUM_DEPCTR(ND), .NUM_UNITS(NU),
      .HALF_MASK(HALF), .MISS_WAIT(MW)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .warp_inst_valid(v), .warp_stall_zero(sz),
      .warp_dep_zero(dz), .warp_dep_mask(dm),
      .warp_unit(un), .warp_yield(yl), .warp_cc_hit(hit),
      .issue_valid(issue_valid), .issue_warp_oh(issue_warp_oh),
      .issue_warp_id(issue_warp_id)
   );

   int nvec = 0;
   int nfail = 0;

   // reference state
   bit m_fv;
   int m_fid;
   bit m_yh;
   int m_busy [NU];
   int m_miss;

   task automatic model_reset();
      m_fv = 0; m_fid = 0; m_yh = 0; m_miss = 0;
      for (int u = 0; u < NU; u++) m_busy[u] = 0;
   endtask

   function automatic bit eligible(int w);
      int u;
      u = int'(un[w*UW +: UW]);
      return v[w] && sz[w] && ((dz[w*ND +: ND] | ~dm[w*ND +: ND]) == '1)
             && m_busy[u] == 0 && !(m_yh && m_fid == w);
   endfunction

   task automatic compare(string tag, bit ev, int eid);
      logic [NW-1:0] eoh;
      eoh = ev ? (NW'(1) << eid) : '0;
      nvec++;
      if (issue_valid !== ev || issue_warp_id !== (ev ? IW'(eid) : '0) ||
          issue_warp_oh !== eoh) begin
         nfail++;
         $display("FAIL %s: got valid=%0b id=%0d oh=%b, expected valid=%0b id=%0d oh=%b",
                  tag, issue_valid, issue_warp_id, issue_warp_oh,
                  ev, ev ? eid : 0, eoh);
      end
   endtask

   // one clock: inputs already driven; predict, clock, check, commit
   task automatic step(string tag);
      bit e [NW];
      bit pv, fire, wt;
      int pid, fid, nmiss, alt;
      for (int w = 0; w < NW; w++) e[w] = eligible(w);
      pv = 0; pid = 0;
      if (m_fv && e[m_fid]) begin pv = 1; pid = m_fid; end
      else for (int w = 0; w < NW; w++) if (e[w]) begin pv = 1; pid = w; end
      fire = 0; fid = pid; wt = 0; nmiss = 0;
      if (pv) begin
         if (hit[pid]) fire = 1;
         else if (m_miss < MW) begin wt = 1; nmiss = m_miss + 1; end
         else begin
            alt = -1;
            for (int w = 0; w < NW; w++) if (w != pid && e[w] && hit[w]) alt = w;
            if (alt >= 0) begin fire = 1; fid = alt; end
            else nmiss = m_miss;
         end
      end
      @(posedge clk);
      @(negedge clk);
      compare(tag, fire, fid);
      for (int u = 0; u < NU; u++) if (m_busy[u] > 0) m_busy[u]--;
      m_miss = nmiss;
      m_yh = fire && yl[fid];
      if (fire) begin
         m_fv = 1; m_fid = fid;
         if (HALF[un[fid*UW +: UW]]) m_busy[un[fid*UW +: UW]] = 1;
      end else if (wt) begin
         m_fv = 1; m_fid = pid;
      end
   endtask

   task automatic quiet();
      v = '0; sz = '1; yl = '0; hit = '1; dz = '1; dm = '0; un = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      int seed;
      int r;
      seed = 7741;
      r = $urandom(seed);
      quiet();
      model_reset();
      // R8: reset state
      repeat (3) begin
         @(negedge clk);
         compare("R8 reset", 0, 0);
      end
      rst_n = 1'b1;
      // R8: registered outputs, one clock to the first issue
      // R4: after reset the youngest eligible warp is chosen
      v = '1;
      step("R4 youngest after reset");
      // R3: greedy hold on warp 7
      step("R3 greedy");
      step("R3 greedy");
      // R4: warp 7 leaves, warp 6 takes over
      v[7] = 1'b0;
      step("R4 switch to youngest");
      // R3: warp 7 returns, warp 6 is kept
      v[7] = 1'b1;
      step("R3 keep over younger");
      step("R3 keep over younger");
      // R2: stall flag and masked dependence counter gate eligibility
      sz[6] = 1'b0;
      step("R2 stall nonzero");
      dm[7*ND + 2] = 1'b1; dz[7*ND + 2] = 1'b0;
      step("R2 dependence pending");
      dm[7*ND + 2] = 1'b0;
      step("R2 unmasked counter ignored");
      dz[7*ND + 2] = 1'b1;
      // R5: yield with a single ready warp
      quiet();
      v[2] = 1'b1; yl[2] = 1'b1;
      step("R5 yield issue");
      step("R5 yield bubble");
      step("R5 yield reissue");
      // R5: yield with another warp ready
      v[4] = 1'b1; yl[4] = 1'b0;
      step("R5 yield other");
      step("R5 yield other");
      // R6: half-width unit 1
      quiet();
      v[1] = 1'b1; un[1*UW +: UW] = 2'd1;
      step("R6 half take");
      step("R6 half busy");
      step("R6 half free");
      // R6: full-width unit 0 every cycle
      un[1*UW +: UW] = 2'd0;
      step("R6 full take");
      step("R6 full take");
      // R7: miss on the focused warp with alternatives ready
      v = '1;
      hit[1] = 1'b0;
      for (int i = 0; i < MW; i++) step("R7 miss hold");
      step("R7 switch after wait");
      step("R7 greedy on new warp");
      // R7: miss with no alternative keeps holding
      quiet();
      v[3] = 1'b1; hit[3] = 1'b0;
      for (int i = 0; i < MW + 3; i++) step("R7 miss no alternative");
      hit[3] = 1'b1;
      step("R7 miss served");
      // random phase covering R1..R7 together
      for (int n = 0; n < 6000; n++) begin
         v   = NW'($urandom) | NW'($urandom);
         sz  = NW'($urandom) | NW'($urandom) | NW'($urandom);
         yl  = NW'($urandom) & NW'($urandom) & NW'($urandom);
         hit = ((n / 50) % 3 == 0) ? ~(NW'($urandom) & NW'($urandom) & NW'($urandom))
                                   : ~(NW'(1) << ($urandom % NW));
         dm  = {$urandom, $urandom} & {$urandom, $urandom};
         dz  = ~({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
         un  = NW*UW'($urandom);
         step("R1 random");
      end
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule